// File: doc/BRIEF.md
# Externally Gated and Triggered Up-Counter

This block is an up-counter whose enable comes from an external signal instead of only a software bit. One of two timer input pins is chosen as the internal trigger. The chosen pin is brought into the clock domain through a flip-flop chain, optionally inverted, and then edge-detected. A small state machine decides whether the counter runs. In gated mode the counter advances only while the trigger is at its active level. In trigger mode an active edge starts the counter, and the counter then runs until software clears the enable bit. A sticky event flag records every start and stop that the external signal causes.

Software controls the block through a write-only port with four addresses. Address 0 holds the counter-enable bit and the slave-mode field. Address 1 holds the trigger-source code. Address 2 holds the two polarity bits. A write to address 3 clears the event flag. The state machine has six states. `ST_IDLE` and `ST_FREE` belong to the plain mode, `ST_GATE_WAIT` and `ST_GATE_RUN` to gated mode, and `ST_TRIG_ARMED` and `ST_TRIG_RUN` to trigger mode.

The transitions are named as follows. *sw-start* (IDLE→FREE, enable set) and *sw-stop* (FREE→IDLE, enable cleared). *gate-open* (GATE_WAIT→GATE_RUN, trigger active and enable set) and *gate-close* (GATE_RUN→GATE_WAIT, trigger inactive or enable cleared). *fire* (TRIG_ARMED→TRIG_RUN, active edge or enable set) and *halt* (TRIG_RUN→TRIG_ARMED, enable cleared). *re-enter*: any state whose mode family no longer matches the mode field moves to that family's resting state, which is IDLE, FREE, GATE_WAIT or TRIG_ARMED.

Top module: `tmr_slave_ctrl`

## Requirements
- R1: While reset is asserted and just after it is released, `cnt_value` is 0, `cnt_running` is 0 and `trig_flag` is 0. All configuration fields are zero.
- R2: In plain mode (mode field 3'b000), `cnt_running` follows the enable bit (address 0, bit 0) one cycle after the write lands. The counter advances by one on every rising clock edge at which `cnt_running` is 1 and holds otherwise. The flag is never set in this mode.
- R3: The counter wraps from all ones to 0, that is, it counts modulo 2^CNT_W.
- R4: In gated mode (mode field 3'b101, address 0 bits 3:1), the counter runs only while the enable bit is 1 and the internal trigger is active. A write that clears the enable bit stops it even with the trigger active.
- R5: With SYNC_STAGES=2, a change on the selected pin reaches `cnt_running` and `trig_flag` at the third rising edge after the pin changes, and not earlier.
- R6: In gated mode the flag is set both when the internal trigger becomes active (count start) and when it becomes inactive (count stop).
- R7: In trigger mode (mode field 3'b110), an inactive-to-active transition of the internal trigger starts the counter, sets the enable bit in hardware and sets the flag.
- R8: In trigger mode the counter keeps running after the trigger input returns inactive. A further active edge while it runs only sets the flag again. The counter stops one cycle after software writes 0 to the enable bit.
- R9: Source code 5'b00101 (address 1, bits 4:0) selects `tin1` and 5'b00110 selects `tin2`. With one pin selected, the other pin has no effect. Any other code holds the internal trigger inactive, whatever the polarity.
- R10: Polarity bits P (address 2, bit 0) and NP (address 2, bit 1): P=1, NP=0 inverts the pin, so a low pin is active. Every other combination passes the pin straight through, so a high pin is active.
- R11: The flag stays set until a write to address 3 with data bit 0 equal to 0. A write there with bit 0 equal to 1 leaves it set.
- R12: Mode codes other than 3'b101 and 3'b110 behave as plain mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timer clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tin1 | input | 1 | First external timer input (asynchronous) |
| tin2 | input | 1 | Second external timer input (asynchronous) |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 2 | Configuration address (0 control, 1 source, 2 polarity, 3 flag clear) |
| cfg_wdata | input | 8 | Configuration write data |
| cnt_value | output | CNT_W | Counter value |
| cnt_running | output | 1 | High while the counter advances on each edge |
| trig_flag | output | 1 | Sticky trigger event flag |

## Verification
The bench times each pin change to the exact edge. A design with a synchronizer one stage short would start counting a cycle early, and one that skipped the edge register would be a cycle late. It checks that trigger mode keeps counting once the pin falls and stops only on the software write; a design that treated trigger mode as gating would stop early. It drives the unselected pin, invalid source codes, inverted polarity and unknown mode codes, where a wrong decode would start the counter or set the flag. It runs the counter past its all-ones value and checks both that a write of 1 to the flag address leaves the flag set and that a write of 0 clears it.

// File: rtl/tmr_slv_pkg.sv
package tmr_slv_pkg;

    localparam logic [2:0] MODE_OFF   = 3'b000;
    localparam logic [2:0] MODE_GATED = 3'b101;
    localparam logic [2:0] MODE_TRIG  = 3'b110;

    localparam logic [4:0] SEL_BASE   = 5'b00101;

    localparam logic [1:0] ADR_CTRL   = 2'd0;
    localparam logic [1:0] ADR_SRC    = 2'd1;
    localparam logic [1:0] ADR_POL    = 2'd2;
    localparam logic [1:0] ADR_FLAG   = 2'd3;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_FREE,
        ST_GATE_WAIT,
        ST_GATE_RUN,
        ST_TRIG_ARMED,
        ST_TRIG_RUN
    } slv_state_e;

    typedef enum logic [1:0] {
        FAM_PLAIN,
        FAM_GATED,
        FAM_TRIG
    } mode_fam_e;

    function automatic mode_fam_e decode_mode(input logic [2:0] m);
        if (m == MODE_GATED) return FAM_GATED;
        if (m == MODE_TRIG)  return FAM_TRIG;
        return FAM_PLAIN;
    endfunction

endpackage

// File: rtl/tmr_slv_insync.sv
module tmr_slv_insync
    import tmr_slv_pkg::*;
#(
    parameter int STAGES = 2,
    parameter int NPIN   = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NPIN-1:0] pins,
    input  logic [4:0]      src_sel,
    input  logic            pol_p,
    input  logic            pol_np,
    output logic            trg_lvl,
    output logic            trg_rise,
    output logic            trg_fall
);

    logic [NPIN-1:0] synced;
    logic            pick_hit;
    logic            pick_bit;
    logic            invert;
    logic            lvl_now;
    logic            lvl_prev;

    for (genvar p = 0; p < NPIN; p++) begin : g_pin
        logic [STAGES-1:0] chain;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                chain <= '0;
            end else begin
                chain <= {chain[STAGES-2:0], pins[p]};
            end
        end
        assign synced[p] = chain[STAGES-1];
    end

    always_comb begin
        pick_hit = 1'b0;
        pick_bit = 1'b0;
        for (int k = 0; k < NPIN; k++) begin
            if (src_sel == SEL_BASE + 5'(k)) begin
                pick_hit = 1'b1;
                pick_bit = synced[k];
            end
        end
    end

    assign invert  = pol_p & ~pol_np;
    assign lvl_now = pick_hit & (pick_bit ^ invert);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lvl_prev <= 1'b0;
        end else begin
            lvl_prev <= lvl_now;
        end
    end

    assign trg_lvl  = lvl_now;
    assign trg_rise = lvl_now & ~lvl_prev;
    assign trg_fall = ~lvl_now & lvl_prev;

endmodule

// File: rtl/tmr_slv_regs.sv
module tmr_slv_regs
    import tmr_slv_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       we,
    input  logic [1:0] addr,
    input  logic [7:0] wdata,
    input  logic       cen_hw_set,
    input  logic       flag_hw_set,
    output logic [2:0] mode,
    output logic       cen,
    output logic [4:0] src_sel,
    output logic       pol_p,
    output logic       pol_np,
    output logic       flag
);

    logic wr_ctrl;
    logic wr_src;
    logic wr_pol;
    logic wr_clr;

    assign wr_ctrl = we && (addr == ADR_CTRL);
    assign wr_src  = we && (addr == ADR_SRC);
    assign wr_pol  = we && (addr == ADR_POL);
    assign wr_clr  = we && (addr == ADR_FLAG) && !wdata[0];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode    <= MODE_OFF;
            src_sel <= '0;
            pol_p   <= 1'b0;
            pol_np  <= 1'b0;
        end else begin
            if (wr_ctrl) begin
                mode <= wdata[3:1];
            end
            if (wr_src) begin
                src_sel <= wdata[4:0];
            end
            if (wr_pol) begin
                pol_p  <= wdata[0];
                pol_np <= wdata[1];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cen <= 1'b0;
        end else if (cen_hw_set) begin
            cen <= 1'b1;
        end else if (wr_ctrl) begin
            cen <= wdata[0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flag <= 1'b0;
        end else if (flag_hw_set) begin
            flag <= 1'b1;
        end else if (wr_clr) begin
            flag <= 1'b0;
        end
    end

endmodule

// File: rtl/tmr_slv_fsm.sv
module tmr_slv_fsm
    import tmr_slv_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [2:0] mode,
    input  logic       cen,
    input  logic       trg_lvl,
    input  logic       trg_rise,
    input  logic       trg_fall,
    output logic       running,
    output logic       cen_hw_set,
    output logic       flag_hw_set
);

    slv_state_e state_q;
    slv_state_e state_d;
    mode_fam_e  fam;
    slv_state_e rest_st;

    assign fam = decode_mode(mode);

    always_comb begin
        unique case (fam)
            FAM_GATED: rest_st = ST_GATE_WAIT;
            FAM_TRIG:  rest_st = ST_TRIG_ARMED;
            default:   rest_st = cen ? ST_FREE : ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE, ST_FREE: begin
                if (fam == FAM_PLAIN) begin
                    state_d = cen ? ST_FREE : ST_IDLE;
                end else begin
                    state_d = rest_st;
                end
            end
            ST_GATE_WAIT, ST_GATE_RUN: begin
                if (fam == FAM_GATED) begin
                    state_d = (trg_lvl && cen) ? ST_GATE_RUN : ST_GATE_WAIT;
                end else begin
                    state_d = rest_st;
                end
            end
            ST_TRIG_ARMED: begin
                if (fam == FAM_TRIG) begin
                    state_d = (trg_rise || cen) ? ST_TRIG_RUN : ST_TRIG_ARMED;
                end else begin
                    state_d = rest_st;
                end
            end
            ST_TRIG_RUN: begin
                if (fam == FAM_TRIG) begin
                    state_d = (cen || trg_rise) ? ST_TRIG_RUN : ST_TRIG_ARMED;
                end else begin
                    state_d = rest_st;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        running     = 1'b0;
        cen_hw_set  = 1'b0;
        flag_hw_set = 1'b0;
        unique case (state_q)
            ST_FREE, ST_GATE_RUN, ST_TRIG_RUN: running = 1'b1;
            default:                           running = 1'b0;
        endcase
        unique case (fam)
            FAM_GATED: flag_hw_set = trg_rise || trg_fall;
            FAM_TRIG: begin
                flag_hw_set = trg_rise;
                cen_hw_set  = trg_rise;
            end
            default: begin
                flag_hw_set = 1'b0;
                cen_hw_set  = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/tmr_slv_counter.sv
module tmr_slv_counter #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         adv,
    output logic [W-1:0] value
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            value <= '0;
        end else if (adv) begin
            value <= value + W'(1);
        end
    end

endmodule

// File: rtl/tmr_slave_ctrl.sv
module tmr_slave_ctrl
    import tmr_slv_pkg::*;
#(
    parameter int CNT_W       = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tin1,
    input  logic             tin2,
    input  logic             cfg_we,
    input  logic [1:0]       cfg_addr,
    input  logic [7:0]       cfg_wdata,
    output logic [CNT_W-1:0] cnt_value,
    output logic             cnt_running,
    output logic             trig_flag
);

    localparam int NPIN = 2;

    logic [2:0] mode_q;
    logic       cen_q;
    logic [4:0] src_q;
    logic       pol_p_q;
    logic       pol_np_q;
    logic       trg_lvl;
    logic       trg_rise;
    logic       trg_fall;
    logic       cen_set;
    logic       flag_set;
    logic       run;

    tmr_slv_insync #(
        .STAGES (SYNC_STAGES),
        .NPIN   (NPIN)
    ) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .pins     ({tin2, tin1}),
        .src_sel  (src_q),
        .pol_p    (pol_p_q),
        .pol_np   (pol_np_q),
        .trg_lvl  (trg_lvl),
        .trg_rise (trg_rise),
        .trg_fall (trg_fall)
    );

    tmr_slv_regs u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .we          (cfg_we),
        .addr        (cfg_addr),
        .wdata       (cfg_wdata),
        .cen_hw_set  (cen_set),
        .flag_hw_set (flag_set),
        .mode        (mode_q),
        .cen         (cen_q),
        .src_sel     (src_q),
        .pol_p       (pol_p_q),
        .pol_np      (pol_np_q),
        .flag        (trig_flag)
    );

    tmr_slv_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .mode        (mode_q),
        .cen         (cen_q),
        .trg_lvl     (trg_lvl),
        .trg_rise    (trg_rise),
        .trg_fall    (trg_fall),
        .running     (run),
        .cen_hw_set  (cen_set),
        .flag_hw_set (flag_set)
    );

    tmr_slv_counter #(
        .W (CNT_W)
    ) u_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .adv   (run),
        .value (cnt_value)
    );

    assign cnt_running = run;

endmodule

// File: rtl/tmr_slave_ctrl_chk.sv
module tmr_slave_ctrl_chk
    import tmr_slv_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cfg_we,
    input logic [1:0]       cfg_addr,
    input logic [7:0]       cfg_wdata,
    input logic [CNT_W-1:0] cnt_value,
    input logic             cnt_running,
    input logic             trig_flag,
    input logic [2:0]       mode_q
);

    logic ctrl_wr;
    logic flag_clr_wr;

    assign ctrl_wr     = cfg_we && (cfg_addr == ADR_CTRL);
    assign flag_clr_wr = cfg_we && (cfg_addr == ADR_FLAG) && !cfg_wdata[0];

    // R1: outputs cleared by reset
    a_r1_reset_clear: assert property (@(posedge clk)
        !rst_n |=> (cnt_value == '0) && !cnt_running && !trig_flag);

    // R2: counter advances by one per running edge
    a_r2_count_step: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_running |=> cnt_value == CNT_W'($past(cnt_value) + 1'b1));

    // R2: counter holds when not running
    a_r2_count_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !cnt_running |=> $stable(cnt_value));

    // R2: flag rises only in gated or trigger mode
    a_r2_flag_source: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(trig_flag) |-> ($past(mode_q) == MODE_GATED || $past(mode_q) == MODE_TRIG));

    // R11: flag sticky until a clearing write
    a_r11_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        trig_flag && !flag_clr_wr |=> trig_flag);

    // R8: running trigger-mode counter continues without control writes
    a_r8_trig_keeps_running: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_running && mode_q == MODE_TRIG && $past(mode_q) == MODE_TRIG
        && !ctrl_wr && !$past(ctrl_wr) |=> cnt_running);

endmodule

bind tmr_slave_ctrl tmr_slave_ctrl_chk #(
    .CNT_W (CNT_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cfg_we      (cfg_we),
    .cfg_addr    (cfg_addr),
    .cfg_wdata   (cfg_wdata),
    .cnt_value   (cnt_value),
    .cnt_running (cnt_running),
    .trig_flag   (trig_flag),
    .mode_q      (mode_q)
);

// File: tb/test_tmr_slave_ctrl.sv
module test_tmr_slave_ctrl;

    localparam int CLK_PERIOD = 10;
    localparam int CW         = 8;
    localparam int CMASK      = (1 << CW) - 1;

    logic          clk;
    logic          rst_n;
    logic          tin1;
    logic          tin2;
    logic          cfg_we;
    logic [1:0]    cfg_addr;
    logic [7:0]    cfg_wdata;
    logic [CW-1:0] cnt_value;
    logic          cnt_running;
    logic          trig_flag;

    tmr_slave_ctrl #(
        .CNT_W       (CW),
        .SYNC_STAGES (2)
    ) i_tmr_slave_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .tin1        (tin1),
        .tin2        (tin2),
        .cfg_we      (cfg_we),
        .cfg_addr    (cfg_addr),
        .cfg_wdata   (cfg_wdata),
        .cnt_value   (cnt_value),
        .cnt_running (cnt_running),
        .trig_flag   (trig_flag)
    );

    initial clk = 1'b0;
    always #(CLK_PERIOD / 2) clk = ~clk;

    int cyc_n = 0;
    always @(posedge clk) cyc_n <= cyc_n + 1;

    // scoreboard queues: 0 = count, 1 = running, 2 = flag
    int    q_cyc[$];
    int    q_kind[$];
    int    q_val[$];
    string q_tag[$];
    int    total = 0;
    int    bad   = 0;
    bit    done  = 1'b0;

    task automatic push_exp(input int kind, input int val, input string tag);
        q_cyc.push_back(cyc_n);
        q_kind.push_back(kind);
        q_val.push_back(val);
        q_tag.push_back(tag);
    endtask

    function automatic int actual_of(input int kind);
        if (kind == 0) return int'(cnt_value);
        if (kind == 1) return int'(cnt_running);
        return int'(trig_flag);
    endfunction

    always @(negedge clk) begin
        #1;
        for (int i = q_cyc.size() - 1; i >= 0; i--) begin
            if (q_cyc[i] <= cyc_n) begin
                int act;
                act = actual_of(q_kind[i]);
                total++;
                if (act != q_val[i]) begin
                    bad++;
                    $display("FAIL %s kind=%0d actual=%0d expected=%0d", q_tag[i], q_kind[i], act, q_val[i]);
                end
                q_cyc.delete(i);
                q_kind.delete(i);
                q_val.delete(i);
                q_tag.delete(i);
            end
        end
    end

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        cfg_we    = 1'b1;
        cfg_addr  = a;
        cfg_wdata = d;
        @(negedge clk);
        cfg_we    = 1'b0;
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            bad++;
            total++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        int base;
        rst_n     = 1'b0;
        tin1      = 1'b0;
        tin2      = 1'b0;
        cfg_we    = 1'b0;
        cfg_addr  = '0;
        cfg_wdata = '0;
        step(3);
        push_exp(0, 0, "R1 count in reset");
        push_exp(1, 0, "R1 running in reset");
        push_exp(2, 0, "R1 flag in reset");
        rst_n = 1'b1;
        step(2);
        push_exp(0, 0, "R1 count after reset");
        push_exp(1, 0, "R1 running after reset");

        // plain mode
        wr(2'd0, 8'h01);
        base = int'(cnt_value);
        step(1);
        push_exp(1, 1, "R2 running follows enable");
        push_exp(0, base, "R2 no count before run");
        step(5);
        push_exp(0, (base + 5) & CMASK, "R2 count advances");
        push_exp(2, 0, "R2 no flag in plain mode");
        wr(2'd0, 8'h00);
        step(1);
        push_exp(1, 0, "R2 stops on enable clear");
        base = int'(cnt_value);
        step(4);
        push_exp(0, base, "R2 count holds");

        // unknown mode code behaves as plain
        wr(2'd0, 8'h0F);
        step(1);
        push_exp(1, 1, "R12 mode 111 acts as plain");
        step(2);
        push_exp(2, 0, "R12 no flag for mode 111");
        wr(2'd0, 8'h00);
        step(1);

        // wrap
        base = int'(cnt_value);
        wr(2'd0, 8'h01);
        step(301);
        push_exp(0, (base + 300) & CMASK, "R3 wraps modulo 2^W");
        wr(2'd0, 8'h00);
        step(2);

        // gated, tin1, active high
        wr(2'd1, 8'h05);
        wr(2'd2, 8'h00);
        wr(2'd3, 8'h00);
        wr(2'd0, 8'h0B);
        step(4);
        push_exp(1, 0, "R4 gate inactive no run");
        push_exp(2, 0, "R6 no flag without edge");
        tin1 = 1'b1;
        step(2);
        push_exp(1, 0, "R5 no run before third edge");
        push_exp(2, 0, "R5 no flag before third edge");
        step(1);
        push_exp(1, 1, "R5 run at third edge");
        push_exp(2, 1, "R6 flag on gate start");
        base = int'(cnt_value);
        step(6);
        push_exp(0, (base + 6) & CMASK, "R4 counts while gate active");
        wr(2'd3, 8'h00);
        push_exp(2, 0, "R11 flag cleared by zero write");
        tin1 = 1'b0;
        step(2);
        push_exp(1, 1, "R5 still running before third edge");
        step(1);
        push_exp(1, 0, "R4 stops when gate inactive");
        push_exp(2, 1, "R6 flag on gate stop");
        base = int'(cnt_value);
        step(4);
        push_exp(0, base, "R4 count held after gate close");
        wr(2'd3, 8'h01);
        push_exp(2, 1, "R11 one write leaves flag set");
        wr(2'd3, 8'h00);
        push_exp(2, 0, "R11 zero write clears flag");

        // gated, inverted polarity (low active)
        wr(2'd2, 8'h01);
        step(1);
        push_exp(1, 1, "R10 low pin active when inverted");
        push_exp(2, 1, "R10 flag on inverted start");
        wr(2'd3, 8'h00);
        tin1 = 1'b1;
        step(3);
        push_exp(1, 0, "R10 high pin stops inverted gate");
        push_exp(2, 1, "R6 flag on inverted stop");

        // source select tin2, tin1 ignored
        wr(2'd0, 8'h00);
        tin2 = 1'b0;
        wr(2'd1, 8'h06);
        wr(2'd2, 8'h00);
        step(2);
        wr(2'd3, 8'h00);
        wr(2'd0, 8'h0B);
        for (int k = 0; k < 8; k++) begin
            tin1 = ~tin1;
            step(1);
        end
        step(3);
        push_exp(1, 0, "R9 unselected pin ignored");
        push_exp(2, 0, "R9 unselected pin sets no flag");
        tin2 = 1'b1;
        step(3);
        push_exp(1, 1, "R9 tin2 gates when selected");
        push_exp(2, 1, "R9 tin2 flag");
        wr(2'd0, 8'h0A);
        step(1);
        push_exp(1, 0, "R4 enable clear stops gated count");

        // unused source code
        wr(2'd0, 8'h00);
        wr(2'd1, 8'h00);
        tin1 = 1'b1;
        tin2 = 1'b1;
        step(1);
        wr(2'd3, 8'h00);
        wr(2'd0, 8'h0B);
        step(6);
        push_exp(1, 0, "R9 unused code holds trigger low");
        push_exp(2, 0, "R9 unused code no flag");
        wr(2'd2, 8'h01);
        step(3);
        push_exp(1, 0, "R9 unused code low when inverted");
        push_exp(2, 0, "R9 unused code no flag inverted");

        // trigger mode on tin2
        wr(2'd0, 8'h00);
        tin1 = 1'b0;
        tin2 = 1'b0;
        wr(2'd2, 8'h00);
        wr(2'd1, 8'h06);
        step(3);
        wr(2'd3, 8'h00);
        wr(2'd0, 8'h0C);
        step(4);
        push_exp(1, 0, "R7 armed not running");
        push_exp(2, 0, "R7 armed no flag");
        tin2 = 1'b1;
        step(2);
        push_exp(1, 0, "R5 trigger not before third edge");
        step(1);
        push_exp(1, 1, "R7 edge starts counter");
        push_exp(2, 1, "R7 flag on trigger");
        tin2 = 1'b0;
        step(8);
        push_exp(1, 1, "R8 keeps running after pin falls");
        base = int'(cnt_value);
        step(3);
        push_exp(0, (base + 3) & CMASK, "R8 counting continues");
        wr(2'd3, 8'h00);
        push_exp(2, 0, "R11 flag cleared in trigger mode");
        tin2 = 1'b1;
        step(3);
        push_exp(2, 1, "R8 second edge sets flag");
        push_exp(1, 1, "R8 second edge keeps running");
        wr(2'd0, 8'h0C);
        step(1);
        push_exp(1, 0, "R8 stops on enable clear");
        base = int'(cnt_value);
        step(3);
        push_exp(0, base, "R8 count held after stop");

        // trigger mode, inverted: falling pin is the active edge
        wr(2'd3, 8'h00);
        wr(2'd2, 8'h01);
        step(2);
        push_exp(2, 0, "R10 inactive edge no flag");
        push_exp(1, 0, "R10 inactive edge no start");
        tin2 = 1'b0;
        step(3);
        push_exp(1, 1, "R10 falling pin triggers inverted");
        push_exp(2, 1, "R10 flag inverted trigger");
        wr(2'd0, 8'h0C);
        step(1);
        push_exp(1, 0, "R8 inverted stop on enable clear");

        step(3);
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule